// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked system reach an external asynchronous static RAM of 128K bytes. A requester presents one read or one write at a time on a valid/ready port with a 17-bit address and 8-bit write data. The controller then runs the memory's active-low chip-enable, output-enable and write-enable strobes, the address bus and a shared 8-bit tri-stated data bus. Read results come back with a one-cycle valid pulse.

Every timing interval is a clock-cycle count set by a parameter. A designer picks these counts to fit the memory's speed grade and the system clock. The defaults suit a 10 ns part on a 100 MHz clock: two cycles of read access, one cycle of write pulse, and one idle cycle whenever the direction of the data bus changes. A write is the interval in which chip-enable and write-enable are both low. Output-enable stays high for the whole of a write, so the memory never drives the bus while the controller does. The controller's own driver turns on one cycle before write-enable falls and turns off one cycle after write-enable rises.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_ce_n, mem_oe_n and mem_we_n are all 1, req_ready is 1, rd_valid is 0 and the controller does not drive mem_dq.
- R2: During a read, mem_ce_n=0, mem_oe_n=0 and mem_we_n=1. During a write, whenever mem_we_n=0 then mem_ce_n=0 and mem_oe_n=1.
- R3: In a write, mem_ce_n goes low one cycle before mem_we_n falls. mem_we_n stays low for exactly WP_CYC cycles. mem_ce_n stays low for one more cycle after mem_we_n rises.
- R4: A read holds mem_ce_n and mem_oe_n low for exactly RD_CYC cycles. mem_dq is captured at the clock edge that ends that interval. It is returned on rd_data with rd_valid=1 for exactly one cycle, in the cycle in which req_ready returns to 1.
- R5: When the accepted request has the opposite direction to the previous one, TA_CYC cycles with all strobes high come before the strobes start. The first request after reset gets no turnaround, and neither does a request with the same direction as the one before it.
- R6: req_ready is 0 from the cycle after acceptance until the operation ends. A read is busy for RD_CYC cycles and a write for WP_CYC+2 cycles, each plus TA_CYC when a turnaround applies.
- R7: req_valid asserted while req_ready is 0 has no effect: no extra memory cycle runs and the memory contents are unchanged.
- R8: While mem_ce_n is 0, mem_addr equals all 17 bits of the accepted request's address and does not change.
- R9: The controller's data driver is on only while mem_oe_n is 1 and mem_ce_n is 0. The written byte is on mem_dq while mem_we_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a read result |
| rd_data | output | 8 | Read result |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus, tri-stated |

## Verification
The bench builds the controller with RD_CYC=3, WP_CYC=2 and TA_CYC=1. With these values the read and write-pulse counters each run through more than one step, so an off-by-one in either counter changes a visible strobe width. It also keeps the turnaround path active. A behavioural memory model responds to the strobes. Mixed random and directed read/write sequences then exercise both turnaround directions and repeated operations of the same direction. Busy requests held on the port test that such requests are ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TURN = 3'd1,
      ST_WSET = 3'd2,
      ST_WPUL = 3'd3,
      ST_WHLD = 3'd4,
      ST_RACC = 3'd5
   } ctl_state_t;

   function automatic int max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 1,
   parameter int TA_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic req_ready,
   output logic cap,
   output logic ce_n,
   output logic oe_n,
   output logic we_n,
   output logic drv
);
   localparam int CMAX = max3(RD_CYC, WP_CYC, TA_CYC);
   localparam int CW   = (CMAX < 2) ? 1 : $clog2(CMAX);

   ctl_state_t st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic op_wr_q, op_wr_d;
   logic seen_q;
   logic accept, need_turn;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   generate
      if (TA_CYC > 0) begin : g_turn
         assign need_turn = seen_q && (op_wr_q != req_write);
      end else begin : g_noturn
         assign need_turn = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      op_wr_d = op_wr_q;
      cap     = 1'b0;
      unique case (st_q)
         ST_IDLE: if (accept) begin
            op_wr_d = req_write;
            if (need_turn) begin
               st_d  = ST_TURN;
               cnt_d = CW'(TA_CYC - 1);
            end else if (req_write) begin
               st_d = ST_WSET;
            end else begin
               st_d  = ST_RACC;
               cnt_d = CW'(RD_CYC - 1);
            end
         end
         ST_TURN: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else if (op_wr_q) st_d = ST_WSET;
            else begin
               st_d  = ST_RACC;
               cnt_d = CW'(RD_CYC - 1);
            end
         end
         ST_WSET: begin
            st_d  = ST_WPUL;
            cnt_d = CW'(WP_CYC - 1);
         end
         ST_WPUL: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else st_d = ST_WHLD;
         end
         ST_WHLD: st_d = ST_IDLE;
         ST_RACC: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else begin
               st_d = ST_IDLE;
               cap  = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         op_wr_q <= 1'b0;
         seen_q  <= 1'b0;
         ce_n    <= 1'b1;
         oe_n    <= 1'b1;
         we_n    <= 1'b1;
         drv     <= 1'b0;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         op_wr_q <= op_wr_d;
         if (accept) seen_q <= 1'b1;
         ce_n <= !(st_d inside {ST_WSET, ST_WPUL, ST_WHLD, ST_RACC});
         oe_n <= (st_d != ST_RACC);
         we_n <= (st_d != ST_WPUL);
         drv  <= (st_d inside {ST_WSET, ST_WPUL, ST_WHLD});
      end
   end

   // R2
   wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (oe_n && !ce_n));
   // R3
   we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> ($past(drv) && !$past(ce_n)));
   // R3
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (!ce_n && drv));
   // R6
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |-> !req_ready);
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
   parameter int AW = 17,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          cap,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] dq_out,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         dq_out   <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
         end
         rd_valid <= cap;
         if (cap) rd_data <= dq_in;
      end
   end

   // R4
   rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
   parameter int AW     = 17,
   parameter int DW     = 8,
   parameter int RD_CYC = 2,
   parameter int WP_CYC = 1,
   parameter int TA_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [AW-1:0] mem_addr,
   inout  wire  [DW-1:0] mem_dq
);
   if (RD_CYC < 1) begin : g_bad_rd
      $error("RD_CYC must be at least 1");
   end
   if (WP_CYC < 1) begin : g_bad_wp
      $error("WP_CYC must be at least 1");
   end
   if (TA_CYC < 0) begin : g_bad_ta
      $error("TA_CYC must not be negative");
   end

   logic cap, drv, accept;
   logic [DW-1:0] dq_out;

   assign accept = req_valid && req_ready;
   assign mem_dq = drv ? dq_out : {DW{1'bz}};

   sram_ctl_seq #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_ready(req_ready), .cap(cap), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
      .we_n(mem_we_n), .drv(drv)
   );

   sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
      .req_wdata(req_wdata), .cap(cap), .dq_in(mem_dq), .mem_addr(mem_addr),
      .dq_out(dq_out), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
   // R9
   drv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> (mem_oe_n && !mem_ce_n));
   // R1
   idle_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !drv);
endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
   localparam int RD = 3, WP = 2, TA = 1;
   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n;
   logic [7:0] rd_data;
   logic [16:0] mem_addr;
   wire  [7:0] mem_dq;

   int n_chk = 0, n_fail = 0;
   logic [7:0] mdl [0:1023];
   logic [7:0] refm [0:1023];
   bit have_prev = 0, prev_wr = 0;

   always #4 clk = ~clk;

   sram_ctl #(.RD_CYC(RD), .WP_CYC(WP), .TA_CYC(TA)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
      .mem_dq(mem_dq)
   );

   // behavioural asynchronous memory
   logic wr_act, rd_en;
   assign wr_act = !mem_ce_n && !mem_we_n;
   assign rd_en  = !mem_ce_n && mem_we_n && !mem_oe_n;
   assign mem_dq = rd_en ? mdl[mem_addr[9:0]] : 8'hzz;
   always @(negedge wr_act) mdl[mem_addr[9:0]] = mem_dq;

   function automatic int exp_busy(bit wr, bit turn);
      return (wr ? WP + 2 : RD) + (turn ? TA : 0);
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic do_op(bit wr, logic [16:0] a, logic [7:0] d, bit junk);
      int busy, we_lo, ce_lo, bad_mode, bad_addr, bad_data, bad_seq, lead_idle;
      bit turn, prev_ce;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      turn = have_prev && (prev_wr != wr);
      @(negedge clk);
      if (junk) begin
         req_write = 1; req_addr = a ^ 17'h00155; req_wdata = ~d;
      end else req_valid = 0;
      busy = 0; we_lo = 0; ce_lo = 0; bad_mode = 0; bad_addr = 0;
      bad_data = 0; bad_seq = 0; lead_idle = 0; prev_ce = 1;
      while (!req_ready && busy < 50) begin
         busy++;
         if (mem_ce_n && ce_lo == 0) lead_idle++;
         if (!mem_ce_n) begin
            ce_lo++;
            if (mem_addr !== a) bad_addr++;
            if (wr && !(mem_oe_n && (mem_we_n == (ce_lo == 1 || ce_lo == WP + 2)))) bad_mode++;
            if (!wr && !(mem_we_n == 1 && mem_oe_n == 0)) bad_mode++;
            if (wr && !mem_we_n && mem_dq !== d) bad_data++;
         end else if (!prev_ce) bad_seq++;
         if (!mem_we_n) we_lo++;
         prev_ce = mem_ce_n;
         @(negedge clk);
      end
      req_valid = 0;
      // R6
      chk(busy == exp_busy(wr, turn), "R6 busy length", busy, exp_busy(wr, turn));
      // R5
      chk(lead_idle == (turn ? TA : 0), "R5 turnaround", lead_idle, turn ? TA : 0);
      // R8
      chk(bad_addr == 0 && bad_seq == 0, "R8 address window", bad_addr, 0);
      if (wr) begin
         // R3, R2
         chk(we_lo == WP && ce_lo == WP + 2 && bad_mode == 0, "R3 write strobes",
             {we_lo[7:0], ce_lo[7:0], bad_mode[7:0]}, {8'(WP), 8'(WP + 2), 8'h0});
         // R9
         chk(bad_data == 0, "R9 write data on bus", bad_data, 0);
         chk(rd_valid == 0, "R4 no rd_valid on write", rd_valid, 0);
         refm[a[9:0]] = d;
      end else begin
         // R4, R2
         chk(ce_lo == RD && we_lo == 0 && bad_mode == 0, "R4 read strobes",
             {ce_lo[7:0], bad_mode[7:0]}, {8'(RD), 8'h0});
         chk(rd_valid == 1 && rd_data == refm[a[9:0]], "R4 read data",
             {rd_valid, rd_data}, {1'b1, refm[a[9:0]]});
         @(negedge clk);
         chk(rd_valid == 0, "R4 rd_valid single cycle", rd_valid, 0);
      end
      // R1
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle after op",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      have_prev = 1; prev_wr = wr;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mdl[i] = 8'h00; refm[i] = 8'h00;
      end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1
      chk(mem_ce_n && mem_oe_n && mem_we_n && req_ready && !rd_valid,
          "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, req_ready, rd_valid}, 5'b11110);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n && req_ready && !rd_valid,
          "R1 idle after reset", {mem_ce_n, mem_oe_n, mem_we_n, req_ready, rd_valid}, 5'b11110);
      do_op(1, 17'h00000, 8'hA5, 0);
      do_op(1, 17'h1FFFF, 8'h5A, 0);
      do_op(0, 17'h1FFFF, 8'h00, 0);
      do_op(0, 17'h00000, 8'h00, 0);
      do_op(1, 17'h0A0A0, 8'h3C, 0);
      // R7: requests held while busy must not run
      do_op(0, 17'h00003, 8'h00, 1);
      do_op(0, 17'h00003 ^ 17'h00155, 8'h00, 0);
      chk(rd_data == refm[10'h156], "R7 busy request ignored", rd_data, refm[10'h156]);
      for (int k = 0; k < 300; k++) begin
         logic [16:0] a;
         a = 17'($urandom);
         if (k % 7 == 0) a[9:0] = 10'h3FF;
         do_op(1'($urandom), a, 8'($urandom), 0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule